// File: doc/BRIEF.md
# Programmable ADC Step Sequencer

This block runs one conversion sequencer of an analog-to-digital subsystem. Software fills a small step table through a simple register port. Each step has a 4-bit channel selector and a 4-bit control nibble. The control nibble selects differential mode, marks the end of the sequence, enables a per-step interrupt event, and routes the temperature sensor. After the sequencer is enabled, a trigger pulse makes it walk the table from step 0. It issues one request per step to an abstract converter and waits for that converter's done handshake before it moves on.

Every result goes into a circular result FIFO, and each read of the result address pops one entry. A status word shows the read pointer, the write pointer, and the empty and full flags. Two sticky flags record a result that was dropped because the FIFO was full and a read made while the FIFO was empty. The sequence length comes from the first step whose end flag is set, or from the size of the table if no end flag is set. Interrupt events can follow any chosen subset of steps.

Top module: `adc_step_sequencer`

## Requirements
- R1: After reset the sequencer is idle and disabled. The result FIFO is empty with both pointers at 0, and both sticky flags are clear.
- R2: The register at address 1 holds channel nibbles and the register at address 2 holds control nibbles, step i at bits 4i+3:4i. Both read back as written. They can be written while the sequencer is disabled. Address 0 bit 0 is the enable.
- R3: A trigger pulse while the sequencer is enabled and idle starts a sequence at step 0. A trigger while it is disabled starts nothing.
- R4: While a step is active, conv_req is high and carries that step's channel nibble on conv_chan, control bit 0 on conv_diff and control bit 3 on conv_temp. The step completes in the cycle where conv_done is high. A channel may repeat across steps.
- R5: Control bit 1 (end) on step k ends the sequence after k+1 conversions. With no end bit set, the sequence ends after NSTEPS conversions.
- R6: irq_evt is high for exactly the one cycle after a step whose control bit 2 (interrupt enable) is set completes. This holds for any subset of steps.
- R7: Results enter the FIFO in conversion order. A read of address 3 returns the oldest result in its low RES_W bits and removes it.
- R8: Address 4 reads the read pointer in bits 7:0, the write pointer in bits 15:8, empty in bit 16 and full in bit 17. The pointers wrap modulo the FIFO depth.
- R9: A result that arrives while the FIFO is full, with no pop in the same cycle, is discarded and sets address 5 bit 0. A pop while the FIFO is empty returns 0, moves no pointer and sets bit 1. Both bits are sticky and are cleared by writing 1 to them.
- R10: A trigger that arrives while a sequence is running has no effect on that sequence and starts no new one.
- R11: Clearing the enable during a sequence lets that sequence finish. Triggers after that start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 3) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| trig | input | 1 | Sequence trigger pulse |
| conv_req | output | 1 | Conversion request for the active step |
| conv_chan | output | 4 | Channel of the active step |
| conv_diff | output | 1 | Differential mode for the active step |
| conv_temp | output | 1 | Temperature sensor select for the active step |
| conv_done | input | 1 | Converter finished the current request |
| conv_data | input | RES_W | Conversion result, valid with conv_done |
| irq_evt | output | 1 | Per-step interrupt event pulse |
| seq_busy | output | 1 | A sequence is running |

## Verification
The bench builds the block with NSTEPS = 8, RES_W = 12 and a FIFO depth of 4. Because the FIFO holds only 4 entries, a single five-step or eight-step sequence fills it, so overflow and the wrap of the pointers appear in the first few hundred cycles. The converter stand-in answers each request after a latency that changes from step to step. This places step completions next to register reads, which exercises a pop and a push landing in the same cycle.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int BUS_W = 32;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MUX    = 3'd1,
    A_CTL    = 3'd2,
    A_RESULT = 3'd3,
    A_FSTAT  = 3'd4,
    A_FLAGS  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic temp;
    logic ie;
    logic endf;
    logic diff;
  } step_ctl_t;

  function automatic logic [NIB_W-1:0] nib_at(input logic [BUS_W-1:0] word,
                                              input int unsigned idx);
    return word[idx*NIB_W +: NIB_W];
  endfunction

  function automatic logic stops_after(input step_ctl_t c, input logic at_last);
    return c.endf | at_last;
  endfunction

  function automatic logic fifo_takes(input logic is_full, input logic pop_ok);
    return !is_full || pop_ok;
  endfunction
endpackage

// File: rtl/seq_step_table.sv
module seq_step_table
  import adcseq_pkg::*;
#(
  parameter int NSTEPS = 8,
  localparam int TBL_W = NSTEPS * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic             en,
  output logic [TBL_W-1:0] mux_word,
  output logic [TBL_W-1:0] ctl_word
);
  logic [NIB_W-1:0] mux_n [NSTEPS];
  logic [NIB_W-1:0] ctl_n [NSTEPS];
  logic wr_mux, wr_ctl, wr_en;

  assign wr_mux = wr && (addr == A_MUX);
  assign wr_ctl = wr && (addr == A_CTL);
  assign wr_en  = wr && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) en <= 1'b0;
    else if (wr_en) en <= wdata[0];
  end

  for (genvar g = 0; g < NSTEPS; g++) begin : g_step
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mux_n[g] <= '0;
        ctl_n[g] <= '0;
      end else begin
        if (wr_mux) mux_n[g] <= nib_at(wdata, g);
        if (wr_ctl) ctl_n[g] <= nib_at(wdata, g);
      end
    end
    assign mux_word[g*NIB_W +: NIB_W] = mux_n[g];
    assign ctl_word[g*NIB_W +: NIB_W] = ctl_n[g];
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mux_word) && $stable(ctl_word) && $stable(en));
endmodule

// File: rtl/seq_step_ctrl.sv
module seq_step_ctrl
  import adcseq_pkg::*;
#(
  parameter int NSTEPS = 8,
  localparam int TBL_W = NSTEPS * NIB_W,
  localparam int IDX_W = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trig,
  input  logic [TBL_W-1:0] mux_word,
  input  logic [TBL_W-1:0] ctl_word,
  input  logic             conv_done,
  output logic             conv_req,
  output logic [NIB_W-1:0] conv_chan,
  output logic             conv_diff,
  output logic             conv_temp,
  output logic             step_done,
  output logic             irq_evt,
  output logic             busy
);
  typedef enum logic {S_IDLE, S_CONV} state_e;
  state_e          state_q;
  logic [IDX_W-1:0] step_q;
  step_ctl_t       cur_ctl;
  logic            at_last, seq_start, seq_end;

  assign busy      = (state_q == S_CONV);
  assign cur_ctl   = step_ctl_t'(ctl_word[{step_q, 2'b00} +: NIB_W]);
  assign conv_chan = mux_word[{step_q, 2'b00} +: NIB_W];
  assign conv_req  = busy;
  assign conv_diff = busy && cur_ctl.diff;
  assign conv_temp = busy && cur_ctl.temp;
  assign at_last   = (step_q == IDX_W'(NSTEPS - 1));
  assign step_done = busy && conv_done;
  assign seq_end   = step_done && stops_after(cur_ctl, at_last);
  assign seq_start = !busy && en && trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      irq_evt <= 1'b0;
    end else begin
      irq_evt <= step_done && cur_ctl.ie;
      if (seq_end) begin
        state_q <= S_IDLE;
        step_q  <= '0;
      end else if (step_done) begin
        step_q <= step_q + 1'b1;
      end else if (seq_start) begin
        state_q <= S_CONV;
        step_q  <= '0;
      end
    end
  end

  p_trig_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> busy && $stable(step_q));
  p_end_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_done && cur_ctl.endf |=> !busy);
  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |-> $past(step_done));
  p_no_start_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !en |=> !busy);
  p_start_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> step_q == '0);
endmodule

// File: rtl/seq_result_fifo.sv
module seq_result_fifo
  import adcseq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              clr_ovf,
  input  logic              clr_unf,
  output logic [DATA_W-1:0] pop_data,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              empty,
  output logic              full,
  output logic              ovf,
  output logic              unf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W:0]    count;
  logic pop_ok, push_ok;

  assign empty    = (count == '0);
  assign full     = (count == (PTR_W+1)'(DEPTH));
  assign pop_ok   = pop && !empty;
  assign push_ok  = push && fifo_takes(full, pop_ok);
  assign pop_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      count <= count + (PTR_W+1)'(push_ok) - (PTR_W+1)'(pop_ok);
      ovf <= (ovf && !clr_ovf) || (push && !push_ok);
      unf <= (unf && !clr_unf) || (pop && empty);
    end
  end

  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> $stable(wr_ptr) && ovf);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_ovf |=> ovf);
  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !clr_unf |=> unf);
  p_pop_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !empty |=> rd_ptr == $past(rd_ptr) + PTR_W'(1));
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
  import adcseq_pkg::*;
#(
  parameter int NSTEPS     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int RES_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             trig,
  output logic             conv_req,
  output logic [3:0]       conv_chan,
  output logic             conv_diff,
  output logic             conv_temp,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             irq_evt,
  output logic             seq_busy
);
  localparam int TBL_W = NSTEPS * NIB_W;
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic             en;
  logic [TBL_W-1:0] mux_word, ctl_word;
  logic             step_done, pop, clr_ovf, clr_unf;
  logic [RES_W-1:0] pop_data;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             empty, full, ovf, unf;

  assign pop     = bus_rd && (bus_addr == A_RESULT);
  assign clr_ovf = bus_wr && (bus_addr == A_FLAGS) && bus_wdata[0];
  assign clr_unf = bus_wr && (bus_addr == A_FLAGS) && bus_wdata[1];

  seq_step_table #(.NSTEPS(NSTEPS)) u_table (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .en(en), .mux_word(mux_word), .ctl_word(ctl_word)
  );

  seq_step_ctrl #(.NSTEPS(NSTEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig),
    .mux_word(mux_word), .ctl_word(ctl_word), .conv_done(conv_done),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_diff(conv_diff),
    .conv_temp(conv_temp), .step_done(step_done), .irq_evt(irq_evt),
    .busy(seq_busy)
  );

  seq_result_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(RES_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(step_done), .push_data(conv_data),
    .pop(pop), .clr_ovf(clr_ovf), .clr_unf(clr_unf), .pop_data(pop_data),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .empty(empty), .full(full),
    .ovf(ovf), .unf(unf)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {31'b0, en};
      A_MUX:    bus_rdata = 32'(mux_word);
      A_CTL:    bus_rdata = 32'(ctl_word);
      A_RESULT: bus_rdata = 32'(pop_data);
      A_FSTAT:  bus_rdata = {14'b0, full, empty, 8'(wr_ptr), 8'(rd_ptr)};
      A_FLAGS:  bus_rdata = {30'b0, unf, ovf};
      default:  bus_rdata = '0;
    endcase
  end

  p_push_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |=> $stable(wr_ptr) || $past(step_done));
endmodule

// File: tb/sim_adc_step_sequencer.sv
`timescale 1ns/1ps
module sim_adc_step_sequencer;
  localparam int NS = 8, D = 4, RW = 12;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, trig = 0, conv_done = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [RW-1:0] conv_data = 0;
  logic conv_req, conv_diff, conv_temp, irq_evt, seq_busy;
  logic [3:0] conv_chan;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  adc_step_sequencer #(.NSTEPS(NS), .FIFO_DEPTH(D), .RES_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig(trig), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_diff(conv_diff), .conv_temp(conv_temp),
    .conv_done(conv_done), .conv_data(conv_data), .irq_evt(irq_evt), .seq_busy(seq_busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_mux, m_ctl;
  logic m_en, m_busy, m_irq, m_ovf, m_unf;
  int m_step, m_wp, m_rp;
  logic [RW-1:0] m_q[$];

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'b0, m_en};
      3'd1: return m_mux;
      3'd2: return m_ctl;
      3'd3: return (m_q.size() == 0) ? 32'd0 : 32'(m_q[0]);
      3'd4: return {14'b0, m_q.size() == D, m_q.size() == 0, 8'(m_wp), 8'(m_rp)};
      3'd5: return {30'b0, m_unf, m_ovf};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mux = 0; m_ctl = 0; m_en = 0; m_busy = 0; m_irq = 0; m_ovf = 0; m_unf = 0;
      m_step = 0; m_wp = 0; m_rp = 0; m_q.delete();
    end else begin
      logic [3:0] c;
      logic did, old_en;
      c = 4'((m_ctl >> (4 * m_step)) & 32'hF);
      did = m_busy && conv_done;
      old_en = m_en;
      if (bus_wr && bus_addr == 3'd5) begin
        if (bus_wdata[0]) m_ovf = 0;
        if (bus_wdata[1]) m_unf = 0;
      end
      if (bus_rd && bus_addr == 3'd3) begin
        if (m_q.size() > 0) begin void'(m_q.pop_front()); m_rp = (m_rp + 1) % D; end
        else m_unf = 1;
      end
      if (did) begin
        if (m_q.size() < D) begin m_q.push_back(conv_data); m_wp = (m_wp + 1) % D; end
        else m_ovf = 1;
      end
      m_irq = did && c[2];
      if (did) begin
        if (c[1] || m_step == NS - 1) begin m_busy = 0; m_step = 0; end
        else m_step++;
      end else if (!m_busy && old_en && trig) begin
        m_busy = 1; m_step = 0;
      end
      if (bus_wr && bus_addr == 3'd0) m_en = bus_wdata[0];
      if (bus_wr && bus_addr == 3'd1) m_mux = bus_wdata;
      if (bus_wr && bus_addr == 3'd2) m_ctl = bus_wdata;
    end
    #1;
    if (rst_n) begin
      logic [3:0] ce;
      ce = 4'((m_ctl >> (4 * m_step)) & 32'hF);
      chk("R5 busy", 32'(seq_busy), 32'(m_busy));
      chk("R4 req", 32'(conv_req), 32'(m_busy));
      chk("R6 irq", 32'(irq_evt), 32'(m_irq));
      if (m_busy) begin
        chk("R4 chan", 32'(conv_chan), (m_mux >> (4 * m_step)) & 32'hF);
        chk("R4 diff", 32'(conv_diff), 32'(ce[0]));
        chk("R4 temp", 32'(conv_temp), 32'(ce[3]));
      end
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  // converter stand-in with varying latency
  int wcnt = 0, lat = 2, nsent = 0;
  logic [RW-1:0] sent[$];
  always @(negedge clk) begin
    if (conv_done) begin
      conv_done <= 0; wcnt = 0;
    end else if (conv_req) begin
      wcnt++;
      if (wcnt >= lat) begin
        conv_data <= {conv_chan, 8'(nsent)};
        sent.push_back({conv_chan, 8'(nsent)});
        nsent++;
        conv_done <= 1;
        lat = 1 + (nsent % 4);
      end
    end
  end

  int n_done = 0, n_irq = 0;
  always @(posedge clk) if (rst_n) begin
    if (conv_req && conv_done) n_done++;
    if (irq_evt) n_irq++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic pulse_trig();
    @(negedge clk); trig = 1; @(negedge clk); trig = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!seq_busy) break; end
  endtask

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, ib;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(seq_busy), 0);
    rd(3'd4, v); chk("R1 fstat", v, 32'h0001_0000);
    rd(3'd5, v); chk("R1 flags", v, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    // R2 configure while disabled; repeated channel 5
    wr(3'd1, 32'h3155_2709);
    wr(3'd2, 32'h0002_5841);
    rd(3'd1, v); chk("R2 mux", v, 32'h3155_2709);
    rd(3'd2, v); chk("R2 ctl", v, 32'h0002_5841);
    // R3 trigger while disabled
    pulse_trig(); repeat (4) @(negedge clk);
    chk("R3 disabled trig", 32'(n_done), 0);
    chk("R3 disabled busy", 32'(seq_busy), 0);
    // R3/R5/R10 enabled run with end on step 4
    wr(3'd0, 1);
    pulse_trig();
    chk("R3 started", 32'(seq_busy), 1);
    repeat (3) @(negedge clk);
    pulse_trig(); // R10 ignored mid-run
    wait_idle(); repeat (4) @(negedge clk);
    chk("R5 end on step 4", 32'(n_done), 5);
    chk("R10 no restart", 32'(seq_busy), 0);
    chk("R6 irq subset", 32'(n_irq), 2);
    rd(3'd4, v); chk("R8 full wrap", v, 32'h0002_0000);
    rd(3'd5, v); chk("R9 overflow", v, 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd3, v); chk("R7 order", v, 32'(sent[i]));
    end
    rd(3'd3, v); chk("R9 empty pop", v, 0);
    rd(3'd5, v); chk("R9 underflow", v, 3);
    wr(3'd5, 1); rd(3'd5, v); chk("R9 w1c ovf", v, 2);
    wr(3'd5, 2); rd(3'd5, v); chk("R9 w1c unf", v, 0);
    rd(3'd4, v); chk("R8 ptrs", v, 32'h0001_0000);
    // R5/R6 no end bit, interrupt on every step
    base = n_done; ib = n_irq;
    wr(3'd2, 32'h4444_4444);
    pulse_trig();
    for (int i = 0; i < 12; i++) rd(3'd3, v); // drain while running
    wait_idle(); repeat (4) @(negedge clk);
    chk("R5 full length", 32'(n_done - base), NS);
    chk("R6 every step", 32'(n_irq - ib), NS);
    for (int i = 0; i < 4; i++) rd(3'd3, v);
    wr(3'd5, 3);
    // R11 disable mid-run
    base = n_done;
    wr(3'd2, 0);
    pulse_trig();
    wr(3'd0, 0);
    chk("R11 still busy", 32'(seq_busy), 1);
    wait_idle(); repeat (4) @(negedge clk);
    chk("R11 finished", 32'(n_done - base), NS);
    base = n_done;
    pulse_trig(); repeat (10) @(negedge clk);
    chk("R11 no new start", 32'(n_done - base), 0);
    chk("R11 idle", 32'(seq_busy), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule